// File: doc/BRIEF.md
# 8-Bit PWM Timer/Counter

This block is an 8-bit counter that advances on a clock-enable pulse (the prescaler tick). It has one compare register and one waveform output. A 2-bit mode register selects one of four modes: free-running, phase-correct PWM, clear-on-compare and fast PWM. The mode sets the counting sequence, the point at which the counter turns around (TOP) and the cycle at which the overflow flag is raised. It also sets the moment a new compare value takes effect.

A 2-bit output-action register chooses how the waveform pin responds to a compare match and to TOP. Whenever that register is non-zero, an override-enable output tells the pin logic to drive the waveform in place of normal port data. Software writes the mode, the output action, the compare value and the counter through write strobes. It clears the two sticky flags by pulsing a write-one clear strobe.

Top module: `pwm_timer8`

## Requirements
- R1: Reset is synchronous and active-high. After reset the count is 0x00, both flags are 0, the waveform output is 0, the override enable is 0, the mode is free-running (00), the output action is 00 and the active compare value is 0x00.
- R2: The counter changes only on a cycle where `tick` is high or `cnt_we` is high. The mode encoding is 00 free-running, 01 phase-correct, 10 clear-on-compare and 11 fast PWM. In modes 00 and 11 the counter counts up and wraps from 0xFF to 0x00.
- R3: In mode 10, TOP is the compare value. On the tick that processes a count equal to the compare value, the counter returns to 0x00 instead of incrementing.
- R4: In modes 00 and 10 a compare write becomes active on the next cycle. In modes 01 and 11 the write goes into a buffer, and the buffer is copied to the active compare on the tick that processes count 0xFF.
- R5: In modes 00, 10 and 11, `ovf_flag` is set by the tick that processes count 0xFF. In mode 01 it is set by the tick that processes count 0x00 while counting down, and not at 0xFF.
- R6: `cmp_flag` is set by the tick that processes a count equal to the active compare value. A 1 on `ovf_clr` or `cmp_clr` clears the matching flag, and a set on the same cycle wins over the clear.
- R7: In modes 00 and 10 a compare match applies the output action to the waveform: 00 none, 01 toggle, 10 drive low, 11 drive high.
- R8: In mode 11, output action 10 drives the waveform low on a match and high at TOP (0xFF). Action 11 does the reverse. Action 01 leaves the waveform unchanged.
- R9: In mode 11, when the active compare value is 0xFF and the upper output-action bit is 1, the match is discarded. The waveform sees only the TOP action and `cmp_flag` is not set.
- R10: Mode 01 counts 0x00 up to 0xFF and back down to 0x00. With output action 10 the waveform goes low on an up-count match and high on a down-count match. Action 11 does the opposite, and actions 00 and 01 leave the waveform unchanged.
- R11: A write to the counter discards any compare match on the next tick. That tick neither sets `cmp_flag`, nor changes the waveform, nor clears the counter in mode 10.
- R12: `wave_oe` is 1 exactly when the stored output action is non-zero, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable (prescaler tick) |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value |
| com_we | input | 1 | Output-action register write strobe |
| com_wdata | input | 2 | Output-action value |
| ocr_we | input | 1 | Compare register write strobe |
| ocr_wdata | input | 8 | Compare value |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter value to load |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| cmp_clr | input | 1 | Write-one clear of the compare flag |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Waveform output |
| wave_oe | output | 1 | Waveform override enable |

## Verification
The checker watches four rules on every cycle. The count holds when there is neither a tick nor a counter write. Neither flag rises without a tick. The cycle after a counter write cannot raise the compare flag. The override enable follows the last output-action write. Several behaviours show up only in the bench's directed scenarios, because each depends on a long history of ticks: the mode-dependent turn points, the buffered compare load at TOP, the waveform actions in each mode, the discarded match at 0xFF in fast PWM, and the overflow at the bottom of a phase-correct cycle.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_PHASE = 2'b01,
    MODE_CTC   = 2'b10,
    MODE_FAST  = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } out_act_e;

  function automatic logic is_pwm(tmr_mode_e m);
    return (m == MODE_PHASE) || (m == MODE_FAST);
  endfunction
endpackage

// File: rtl/tmr_cmp_buffer.sv
module tmr_cmp_buffer
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  tmr_mode_e    mode,
  input  logic         ocr_we,
  input  logic [W-1:0] ocr_wdata,
  input  logic         top_ev,
  output logic [W-1:0] ocr_act
);
  logic [W-1:0] ocr_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (ocr_we) ocr_buf <= ocr_wdata;
      if (is_pwm(mode)) begin
        // buffered: the active value changes only when TOP is processed
        if (top_ev) ocr_act <= ocr_buf;
      end else if (ocr_we) begin
        ocr_act <= ocr_wdata;
      end
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] ocr_act,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         match_raw,
  output logic         top_ev,
  output logic         ovf_ev
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic block_q;
  logic step;
  logic at_max, at_zero, cmp_eq;

  assign step    = tick && !cnt_we;
  assign at_max  = (cnt == MAXV);
  assign at_zero = (cnt == '0);
  assign cmp_eq  = (cnt == ocr_act);

  assign match_raw = step && cmp_eq && !block_q;
  assign top_ev    = step && at_max;
  assign ovf_ev    = (mode == MODE_PHASE) ? (step && at_zero && dir_down)
                                          : (step && at_max);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      block_q  <= 1'b0;
    end else begin
      if (mode != MODE_PHASE) dir_down <= 1'b0;
      if (cnt_we) begin
        cnt     <= cnt_wdata;
        block_q <= 1'b1;
      end else if (tick) begin
        block_q <= 1'b0;
        unique case (mode)
          MODE_CTC:   cnt <= (cmp_eq && !block_q) ? '0 : cnt + ONE;
          MODE_PHASE: begin
            if (!dir_down) begin
              if (at_max) begin
                dir_down <= 1'b1;
                cnt      <= MAXV - ONE;
              end else begin
                cnt <= cnt + ONE;
              end
            end else begin
              if (at_zero) begin
                dir_down <= 1'b0;
                cnt      <= ONE;
              end else begin
                cnt <= cnt - ONE;
              end
            end
          end
          default:    cnt <= cnt + ONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
  import pwm_timer8_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tmr_mode_e mode,
  input  out_act_e  act,
  input  logic      match_raw,
  input  logic      top_ev,
  input  logic      dir_down,
  input  logic      ocr_is_max,
  output logic      match_ev,
  output logic      wave
);
  logic suppress;

  // fast PWM: a match that lands on TOP with a set/clear action is dropped
  assign suppress = (mode == MODE_FAST) && act[1] && ocr_is_max;
  assign match_ev = match_raw && !suppress;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
    end else begin
      unique case (mode)
        MODE_FAST: begin
          if (top_ev && act[1])        wave <= ~act[0];
          else if (match_ev && act[1]) wave <= act[0];
        end
        MODE_PHASE: begin
          if (match_ev && act[1]) wave <= dir_down ? ~act[0] : act[0];
        end
        default: begin
          if (match_ev) begin
            unique case (act)
              ACT_TOGGLE: wave <= ~wave;
              ACT_LOW:    wave <= 1'b0;
              ACT_HIGH:   wave <= 1'b1;
              default:    wave <= wave;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic clk,
  input  logic rst,
  input  logic ovf_ev,
  input  logic match_ev,
  input  logic ovf_clr,
  input  logic cmp_clr,
  output logic ovf_flag,
  output logic cmp_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (ovf_ev)       ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (match_ev)     cmp_flag <= 1'b1;
      else if (cmp_clr) cmp_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         mode_we,
  input  logic [1:0]   mode_wdata,
  input  logic         com_we,
  input  logic [1:0]   com_wdata,
  input  logic         ocr_we,
  input  logic [W-1:0] ocr_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         ovf_clr,
  input  logic         cmp_clr,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         wave_out,
  output logic         wave_oe
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  tmr_mode_e    mode_q;
  out_act_e     act_q;
  logic [W-1:0] ocr_act;
  logic         dir_down, match_raw, match_ev, top_ev, ovf_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_FREE;
      act_q   <= ACT_NONE;
      wave_oe <= 1'b0;
    end else begin
      if (mode_we) mode_q <= tmr_mode_e'(mode_wdata);
      if (com_we) begin
        act_q   <= out_act_e'(com_wdata);
        wave_oe <= |com_wdata;
      end
    end
  end

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_q), .ocr_act(ocr_act),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt(count), .dir_down(dir_down),
    .match_raw(match_raw), .top_ev(top_ev), .ovf_ev(ovf_ev)
  );

  tmr_cmp_buffer #(.W(W)) u_ocr (
    .clk(clk), .rst(rst), .mode(mode_q), .ocr_we(ocr_we),
    .ocr_wdata(ocr_wdata), .top_ev(top_ev), .ocr_act(ocr_act)
  );

  tmr_wavegen u_wave (
    .clk(clk), .rst(rst), .mode(mode_q), .act(act_q), .match_raw(match_raw),
    .top_ev(top_ev), .dir_down(dir_down), .ocr_is_max(ocr_act == MAXV),
    .match_ev(match_ev), .wave(wave_out)
  );

  tmr_flags u_flags (
    .clk(clk), .rst(rst), .ovf_ev(ovf_ev), .match_ev(match_ev),
    .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag)
  );
endmodule

// File: rtl/pwm_timer8_checker.sv
module pwm_timer8_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         cnt_we,
  input logic         com_we,
  input logic [1:0]   com_wdata,
  input logic [W-1:0] count,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic         wave_out,
  input logic         wave_oe
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !ovf_flag && !cmp_flag && !wave_out && !wave_oe));

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_we) |=> $stable(count));

  assert_ovf_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(tick) && !$past(cnt_we)));

  assert_cmp_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> ($past(tick) && !$past(cnt_we)));

  assert_write_blocks_match_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_we) && tick && !cnt_we) |=> !$rose(cmp_flag));

  assert_oe_tracks_action_R12: assert property (@(posedge clk) disable iff (rst)
    com_we |=> (wave_oe == ($past(com_wdata) != 2'b00)));
endmodule

bind pwm_timer8 pwm_timer8_checker #(.W(W)) u_checker (
  .clk(clk), .rst(rst), .tick(tick), .cnt_we(cnt_we), .com_we(com_we),
  .com_wdata(com_wdata), .count(count), .ovf_flag(ovf_flag),
  .cmp_flag(cmp_flag), .wave_out(wave_out), .wave_oe(wave_oe)
);

// File: tb/tb_pwm_timer8.sv
`timescale 1ns/1ps
module tb_pwm_timer8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = '0;
  logic       com_we = 1'b0;
  logic [1:0] com_wdata = '0;
  logic       ocr_we = 1'b0;
  logic [7:0] ocr_wdata = '0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       ovf_clr = 1'b0;
  logic       cmp_clr = 1'b0;
  logic [7:0] count;
  logic       ovf_flag, cmp_flag, wave_out, wave_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pwm_timer8 dut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
    end
    tick = 1'b0;
  endtask

  task automatic wr_mode(input logic [1:0] v);
    mode_we = 1'b1; mode_wdata = v; cyc(); mode_we = 1'b0;
  endtask
  task automatic wr_com(input logic [1:0] v);
    com_we = 1'b1; com_wdata = v; cyc(); com_we = 1'b0;
  endtask
  task automatic wr_ocr(input logic [7:0] v);
    ocr_we = 1'b1; ocr_wdata = v; cyc(); ocr_we = 1'b0;
  endtask
  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1'b1; cnt_wdata = v; cyc(); cnt_we = 1'b0;
  endtask
  task automatic clear_flags();
    ovf_clr = 1'b1; cmp_clr = 1'b1; cyc(); ovf_clr = 1'b0; cmp_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0; cyc();
    check("R1", "count", count, 8'h00);
    check("R1", "ovf_flag", ovf_flag, 0);
    check("R1", "cmp_flag", cmp_flag, 0);
    check("R1", "wave_out", wave_out, 0);
    check("R1", "wave_oe", wave_oe, 0);
  endtask

  task automatic t_free_run();
    ticks(10);
    check("R2", "count after 10 ticks", count, 10);
    for (int i = 0; i < 5; i++) cyc();
    check("R2", "count holds without tick", count, 10);
    clear_flags();
    wr_cnt(8'hFE);
    ticks(1);
    check("R2", "count at 0xFF", count, 8'hFF);
    check("R5", "no overflow before MAX processed", ovf_flag, 0);
    ticks(1);
    check("R2", "wrap to zero", count, 8'h00);
    check("R5", "overflow at MAX in mode 00", ovf_flag, 1);
    clear_flags();
    check("R6", "overflow cleared by write-one", ovf_flag, 0);
  endtask

  task automatic t_write_block();
    wr_ocr(8'h20);
    wr_cnt(8'h20);
    clear_flags();
    ticks(1);
    check("R11", "match after counter write discarded", cmp_flag, 0);
    check("R11", "count advanced", count, 8'h21);
    wr_cnt(8'h1F);
    ticks(2);
    check("R4", "immediate compare in mode 00 matches", cmp_flag, 1);
    clear_flags();
    check("R6", "compare flag cleared by write-one", cmp_flag, 0);
  endtask

  task automatic t_ctc();
    wr_mode(2'b10);
    wr_ocr(8'd5);
    wr_com(2'b01);
    check("R12", "override enable with action 01", wave_oe, 1);
    wr_cnt(8'd0);
    clear_flags();
    ticks(5);
    check("R3", "count reaches compare", count, 5);
    check("R6", "no match before compare processed", cmp_flag, 0);
    ticks(1);
    check("R3", "counter cleared after match", count, 0);
    check("R6", "match flag at compare", cmp_flag, 1);
    check("R7", "toggle to high", wave_out, 1);
    ticks(6);
    check("R7", "toggle back to low", wave_out, 0);
    wr_com(2'b11);
    ticks(6);
    check("R7", "set on match", wave_out, 1);
    wr_com(2'b10);
    ticks(6);
    check("R7", "clear on match", wave_out, 0);
    check("R5", "no overflow when TOP below MAX", ovf_flag, 0);
    wr_com(2'b00);
    check("R12", "override enable off with action 00", wave_oe, 0);
  endtask

  task automatic t_fast();
    wr_mode(2'b11);
    wr_com(2'b10);
    wr_cnt(8'd6);
    wr_ocr(8'h80);
    clear_flags();
    ticks(123);
    check("R4", "buffered compare not active before TOP", cmp_flag, 0);
    check("R2", "count past buffered value", count, 8'h81);
    wr_cnt(8'hF0);
    ticks(15);
    check("R8", "output low before TOP", wave_out, 0);
    check("R5", "no overflow before TOP", ovf_flag, 0);
    ticks(1);
    check("R2", "fast PWM wraps", count, 0);
    check("R8", "action 10 sets at TOP", wave_out, 1);
    check("R5", "overflow at MAX in mode 11", ovf_flag, 1);
    clear_flags();
    ticks(128);
    check("R8", "output high until match", wave_out, 1);
    ticks(1);
    check("R4", "buffered compare loaded at TOP", cmp_flag, 1);
    check("R8", "action 10 clears at match", wave_out, 0);
    wr_com(2'b01);
    ticks(256);
    check("R8", "action 01 leaves output unchanged", wave_out, 0);
    check("R12", "override enable with action 01", wave_oe, 1);
    wr_com(2'b11);
    ticks(256);
    check("R8", "action 11 sets at match", wave_out, 1);
  endtask

  task automatic t_suppress();
    wr_ocr(8'hFF);
    ticks(127);
    check("R8", "action 11 clears at TOP", wave_out, 0);
    clear_flags();
    ticks(255);
    check("R9", "count at MAX", count, 8'hFF);
    ticks(1);
    check("R9", "match at TOP discarded", cmp_flag, 0);
    check("R9", "output held by TOP action", wave_out, 0);
    check("R5", "overflow still raised", ovf_flag, 1);
  endtask

  task automatic t_phase();
    wr_com(2'b00);
    wr_mode(2'b01);
    wr_ocr(8'h40);
    clear_flags();
    wr_cnt(8'hFE);
    ticks(2);
    check("R10", "turns down after MAX", count, 8'hFE);
    check("R5", "no overflow at MAX in mode 01", ovf_flag, 0);
    clear_flags();
    wr_com(2'b10);
    ticks(190);
    check("R10", "down-count reaches compare", count, 8'h40);
    check("R10", "output low before down match", wave_out, 0);
    ticks(1);
    check("R10", "action 10 sets on down match", wave_out, 1);
    check("R6", "match flag on down match", cmp_flag, 1);
    ticks(63);
    check("R10", "down-count reaches bottom", count, 0);
    check("R5", "no overflow before bottom processed", ovf_flag, 0);
    ticks(1);
    check("R10", "turns up after bottom", count, 1);
    check("R5", "overflow at bottom in mode 01", ovf_flag, 1);
    ticks(63);
    check("R10", "output high until up match", wave_out, 1);
    ticks(1);
    check("R10", "action 10 clears on up match", wave_out, 0);
    check("R10", "count after up match", count, 8'h41);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_write_block();
    t_ctc();
    t_fast();
    t_suppress();
    t_phase();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end
endmodule